// File: doc/BRIEF.md
# DMA Scatter Descriptor Splitter

This block turns a single memory transfer request into a list of physical-region descriptors for a bus-master disk DMA engine. The request gives a start byte address and a byte length. The block returns descriptors one at a time on a valid/ready stream. Each descriptor is a buffer address plus a 32-bit count word. Bit 31 of the count word marks the final descriptor, and the low bits carry the byte count of that region.

Every region stays inside one aligned segment of 2^SEG_BITS bytes, which is 64 KiB by default. A region therefore never holds more bytes than a segment, and it never runs past the next segment boundary.

Before it emits anything, the block works out how many regions the request needs. A request is refused without emitting a single descriptor if its start address is odd, if its length is zero, or if it would need more regions than the table holds. Each refusal carries a reason code. The end of an accepted request is flagged in the same cycle as the handshake of its final descriptor, together with the number of regions produced.

Top module: `prd_table_gen`

## Requirements
- R1: A request with an odd start address is refused. One cycle after acceptance, err_o pulses for one cycle with err_code_o = 1, and no descriptor is emitted.
- R2: A request with an even start address and a length of zero is refused with err_code_o = 2 and no descriptor. An odd address takes precedence over a zero length.
- R3: The number of regions equals the number of aligned segments that the byte range touches: ceil((start mod 2^SEG_BITS + length) / 2^SEG_BITS). If this exceeds MAX_ENTRIES, the request is refused with err_code_o = 3 and no descriptor.
- R4: No descriptor's byte count (count word bits SEG_BITS..0) exceeds 2^SEG_BITS, and it is never zero.
- R5: A descriptor's byte count never exceeds 2^SEG_BITS minus the low SEG_BITS bits of its address. Regions never cross a segment boundary. Each region is as large as this limit and the bytes still remaining allow.
- R6: Bit 31 of the count word is 1 on the final descriptor of a request and 0 on every other descriptor. Count word bits 30..SEG_BITS+1 are 0.
- R7: The first descriptor's address is the start address. Each later address is the previous address plus the previous byte count. The byte counts add up to the request length.
- R8: done_o is 1 exactly in the cycle where the final descriptor is handshaken (desc_valid_o and desc_ready_i both 1). In that cycle done_count_o equals the number of regions.
- R9: While desc_valid_o is 1 and desc_ready_i is 0, the descriptor address and count word stay unchanged in the next cycle.
- R10: req_ready_o is 1 only when no descriptor is pending. It is 0 whenever desc_valid_o is 1.
- R11: After reset, req_ready_o is 1, and desc_valid_o, done_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Transfer length in bytes |
| desc_valid_o | output | 1 | Descriptor present |
| desc_ready_i | input | 1 | Descriptor taken when high with desc_valid_o |
| desc_addr_o | output | ADDR_W | Region buffer address |
| desc_cnt_o | output | 32 | Count word: bit 31 final flag, low bits byte count |
| done_o | output | 1 | Final descriptor handshake of an accepted request |
| done_count_o | output | $clog2(MAX_ENTRIES+1) | Regions in the finished request |
| err_o | output | 1 | One-cycle refusal pulse |
| err_code_o | output | 2 | Refusal reason: 1 odd, 2 empty, 3 too many regions |

## Verification
The bench builds the block with 8-bit addresses and lengths, 16-byte segments (SEG_BITS = 4) and a 4-entry table. At that scale every segment offset, both parities and every length from 0 to 70 can be swept. The sweep covers single-region requests, requests that fill a segment exactly, requests that straddle several boundaries, and the step from exactly MAX_ENTRIES regions to one too many. Downstream stalls are interleaved so that held descriptors are seen at every position in the list.

// File: rtl/prd_pkg.sv
package prd_pkg;
  typedef enum logic [1:0] {
    REJ_NONE  = 2'd0,
    REJ_ODD   = 2'd1,
    REJ_EMPTY = 2'd2,
    REJ_LONG  = 2'd3
  } rej_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } st_e;
endpackage

// File: rtl/prd_plan.sv
// Pre-checks a request and counts the segments its byte range touches.
module prd_plan #(
  parameter int LEN_W       = 32,
  parameter int SEG_BITS    = 16,
  parameter int MAX_ENTRIES = 16,
  localparam int ENT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic                odd_i,
  input  logic [SEG_BITS-1:0] off_i,
  input  logic [LEN_W-1:0]    len_i,
  output prd_pkg::rej_e       rej_o,
  output logic [ENT_W-1:0]    n_entries_o
);
  localparam int SUM_W = LEN_W + 2;
  localparam logic [SUM_W-1:0] SEG_M1 = {{(SUM_W-SEG_BITS){1'b0}}, {SEG_BITS{1'b1}}};

  logic [SUM_W-1:0] span;
  logic [SUM_W-1:0] segs;

  always_comb begin
    span = {{(SUM_W-SEG_BITS){1'b0}}, off_i} + {2'b00, len_i} + SEG_M1;
    segs = span >> SEG_BITS;
    n_entries_o = ENT_W'(segs);
    if (odd_i)                          rej_o = prd_pkg::REJ_ODD;
    else if (len_i == '0)               rej_o = prd_pkg::REJ_EMPTY;
    else if (segs > SUM_W'(MAX_ENTRIES)) rej_o = prd_pkg::REJ_LONG;
    else                                rej_o = prd_pkg::REJ_NONE;
  end
endmodule

// File: rtl/prd_chunk.sv
// Size of the region starting at the current address.
module prd_chunk #(
  parameter int LEN_W    = 32,
  parameter int SEG_BITS = 16
) (
  input  logic [SEG_BITS-1:0] off_i,
  input  logic [LEN_W-1:0]    rem_i,
  output logic [SEG_BITS:0]   chunk_o,
  output logic                last_o
);
  logic [SEG_BITS:0] room;
  logic              rem_big;

  always_comb begin
    room    = {1'b1, {SEG_BITS{1'b0}}} - {1'b0, off_i};
    rem_big = rem_i > {{(LEN_W-SEG_BITS-1){1'b0}}, room};
    last_o  = !rem_big;
    chunk_o = rem_big ? room : rem_i[SEG_BITS:0];
  end
endmodule

// File: rtl/prd_ctrl.sv
// Request intake, walk state and refusal reporting.
module prd_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 32,
  parameter int SEG_BITS    = 16,
  parameter int MAX_ENTRIES = 16,
  localparam int ENT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  prd_pkg::rej_e      rej_i,
  input  logic [ENT_W-1:0]   n_entries_i,
  input  logic [SEG_BITS:0]  chunk_i,
  input  logic               last_i,
  input  logic               desc_ready_i,
  output logic               req_ready_o,
  output logic               busy_o,
  output logic [ADDR_W-1:0]  cur_addr_o,
  output logic [LEN_W-1:0]   rem_o,
  output logic [ENT_W-1:0]   total_o,
  output logic               err_o,
  output logic [1:0]         err_code_o
);
  prd_pkg::st_e      st_q;
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  rem_q;
  logic [ENT_W-1:0]  tot_q;
  logic              err_q;
  prd_pkg::rej_e     code_q;
  logic              accept;

  assign req_ready_o = (st_q == prd_pkg::ST_IDLE);
  assign busy_o      = (st_q == prd_pkg::ST_EMIT);
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= prd_pkg::ST_IDLE;
      cur_q  <= '0;
      rem_q  <= '0;
      tot_q  <= '0;
      err_q  <= 1'b0;
      code_q <= prd_pkg::REJ_NONE;
    end else begin
      err_q <= 1'b0;
      case (st_q)
        prd_pkg::ST_IDLE: begin
          if (accept) begin
            if (rej_i != prd_pkg::REJ_NONE) begin
              err_q  <= 1'b1;
              code_q <= rej_i;
            end else begin
              st_q  <= prd_pkg::ST_EMIT;
              cur_q <= req_addr_i;
              rem_q <= req_len_i;
              tot_q <= n_entries_i;
            end
          end
        end
        default: begin
          if (desc_ready_i) begin
            cur_q <= cur_q + ADDR_W'(chunk_i);
            rem_q <= rem_q - LEN_W'(chunk_i);
            if (last_i) st_q <= prd_pkg::ST_IDLE;
          end
        end
      endcase
    end
  end

  assign cur_addr_o = cur_q;
  assign rem_o      = rem_q;
  assign total_o    = tot_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;
endmodule

// File: rtl/prd_table_gen.sv
module prd_table_gen #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 32,
  parameter int SEG_BITS    = 16,
  parameter int MAX_ENTRIES = 16,
  localparam int ENT_W      = $clog2(MAX_ENTRIES + 1),
  localparam int CNT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              desc_valid_o,
  input  logic              desc_ready_i,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic [CNT_W-1:0]  desc_cnt_o,
  output logic              done_o,
  output logic [ENT_W-1:0]  done_count_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);
  prd_pkg::rej_e     rej;
  logic [ENT_W-1:0]  n_entries;
  logic [SEG_BITS:0] chunk;
  logic              last;
  logic              busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  rem;
  logic [ENT_W-1:0]  total;

  prd_plan #(
    .LEN_W(LEN_W), .SEG_BITS(SEG_BITS), .MAX_ENTRIES(MAX_ENTRIES)
  ) u_plan (
    .odd_i       (req_addr_i[0]),
    .off_i       (req_addr_i[SEG_BITS-1:0]),
    .len_i       (req_len_i),
    .rej_o       (rej),
    .n_entries_o (n_entries)
  );

  prd_chunk #(
    .LEN_W(LEN_W), .SEG_BITS(SEG_BITS)
  ) u_chunk (
    .off_i   (cur_addr[SEG_BITS-1:0]),
    .rem_i   (rem),
    .chunk_o (chunk),
    .last_o  (last)
  );

  prd_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEG_BITS(SEG_BITS), .MAX_ENTRIES(MAX_ENTRIES)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .rej_i       (rej),
    .n_entries_i (n_entries),
    .chunk_i     (chunk),
    .last_i      (last),
    .desc_ready_i(desc_ready_i),
    .req_ready_o (req_ready_o),
    .busy_o      (busy),
    .cur_addr_o  (cur_addr),
    .rem_o       (rem),
    .total_o     (total),
    .err_o       (err_o),
    .err_code_o  (err_code_o)
  );

  assign desc_valid_o = busy;
  assign desc_addr_o  = cur_addr;
  assign desc_cnt_o   = {last, {(CNT_W-SEG_BITS-2){1'b0}}, chunk};
  assign done_o       = busy && desc_ready_i && last;
  assign done_count_o = total;
endmodule

// File: rtl/prd_table_gen_chk.sv
module prd_table_gen_chk #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 32,
  parameter int SEG_BITS    = 16,
  parameter int MAX_ENTRIES = 16,
  localparam int ENT_W      = $clog2(MAX_ENTRIES + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_addr_bit0_i,
  input logic [LEN_W-1:0]  req_len_i,
  input logic              desc_valid_o,
  input logic              desc_ready_i,
  input logic [ADDR_W-1:0] desc_addr_o,
  input logic [31:0]       desc_cnt_o,
  input logic              done_o,
  input logic [ENT_W-1:0]  done_count_o,
  input logic              err_o,
  input logic [1:0]        err_code_o
);
  localparam logic [SEG_BITS+1:0] SEG_SZ = {2'b01, {SEG_BITS{1'b0}}};

  logic [SEG_BITS+1:0] cnt_x;
  logic [SEG_BITS+1:0] off_x;
  assign cnt_x = {1'b0, desc_cnt_o[SEG_BITS:0]};
  assign off_x = {2'b00, desc_addr_o[SEG_BITS-1:0]};

  assert_odd_refused_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && err_code_o == 2'd1) |-> $past(req_addr_bit0_i && req_valid_i && req_ready_o));

  assert_empty_refused_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && err_code_o == 2'd2) |-> ($past(req_len_i) == '0 && !$past(req_addr_bit0_i)));

  assert_done_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_count_o != '0 && done_count_o <= ENT_W'(MAX_ENTRIES)));

  assert_size_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (cnt_x <= SEG_SZ && cnt_x != '0));

  assert_no_cross_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (cnt_x + off_x <= SEG_SZ));

  assert_pad_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (desc_cnt_o[30:SEG_BITS+1] == '0));

  assert_addr_chain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && desc_ready_i && !desc_cnt_o[31]) |=>
      (desc_valid_o && desc_addr_o == $past(desc_addr_o) + ADDR_W'($past(desc_cnt_o[SEG_BITS:0]))));

  assert_done_on_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (desc_valid_o && desc_ready_i && desc_cnt_o[31]));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i) |=>
      (desc_valid_o && $stable(desc_addr_o) && $stable(desc_cnt_o)));

  assert_busy_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> !req_ready_o);

  assert_err_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!desc_valid_o && $past(req_valid_i && req_ready_o)));
endmodule

bind prd_table_gen prd_table_gen_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEG_BITS(SEG_BITS), .MAX_ENTRIES(MAX_ENTRIES)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_addr_bit0_i(req_addr_i[0]),
  .req_len_i      (req_len_i),
  .desc_valid_o   (desc_valid_o),
  .desc_ready_i   (desc_ready_i),
  .desc_addr_o    (desc_addr_o),
  .desc_cnt_o     (desc_cnt_o),
  .done_o         (done_o),
  .done_count_o   (done_count_o),
  .err_o          (err_o),
  .err_code_o     (err_code_o)
);

// File: tb/sim_prd_table_gen.sv
`timescale 1ns/1ps
module sim_prd_table_gen;
  localparam int AW = 8;
  localparam int LW = 8;
  localparam int SB = 4;
  localparam int ME = 4;
  localparam int SEG = 1 << SB;
  localparam int EW = $clog2(ME + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          desc_valid;
  logic          desc_ready = 1'b0;
  logic [AW-1:0] desc_addr;
  logic [31:0]   desc_cnt;
  logic          done;
  logic [EW-1:0] done_count;
  logic          err;
  logic [1:0]    err_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  prd_table_gen #(.ADDR_W(AW), .LEN_W(LW), .SEG_BITS(SB), .MAX_ENTRIES(ME)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .desc_valid_o(desc_valid),
    .desc_ready_i(desc_ready), .desc_addr_o(desc_addr), .desc_cnt_o(desc_cnt),
    .done_o(done), .done_count_o(done_count), .err_o(err), .err_code_o(err_code)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input int a, input int l);
    int code;
    int n;
    int ea;
    int er;
    int k;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 idle ready", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = AW'(a);
    req_len   = LW'(l);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = ((a % SEG) + l + SEG - 1) / SEG;
    if (a % 2 == 1)  code = 1;
    else if (l == 0) code = 2;
    else if (n > ME) code = 3;
    else             code = 0;
    if (code != 0) begin
      if (code == 1)      chk(err && err_code == 2'd1, "R1 odd refusal", {err, err_code}, 5);
      else if (code == 2) chk(err && err_code == 2'd2, "R2 empty refusal", {err, err_code}, 6);
      else                chk(err && err_code == 2'd3, "R3 table overflow refusal", {err, err_code}, 7);
      chk(!desc_valid, "R3 no descriptor on refusal", desc_valid, 0);
      @(negedge clk);
      chk(!err && !desc_valid, "R1 refusal pulse ends", {err, desc_valid}, 0);
    end else begin
      ea = a;
      er = l;
      k  = 0;
      while (er > 0) begin
        int sp;
        int c;
        bit lst;
        logic [AW-1:0] ha;
        logic [31:0]   hc;
        sp  = SEG - (ea % SEG);
        c   = (er < sp) ? er : sp;
        lst = (er == c);
        if (((a + l + k) % 3) == 0) begin
          desc_ready = 1'b0;
          #1;
          chk(desc_valid && !req_ready, "R10 busy blocks requests", {desc_valid, req_ready}, 2);
          chk(!done, "R8 no done while stalled", done, 0);
          ha = desc_addr;
          hc = desc_cnt;
          @(posedge clk);
          @(negedge clk);
          chk(desc_valid && desc_addr == ha && desc_cnt == hc, "R9 hold under stall",
              {desc_addr, desc_cnt}, {ha, hc});
        end
        desc_ready = 1'b1;
        #1;
        chk(desc_valid == 1'b1, "R7 descriptor present", desc_valid, 1);
        chk(desc_addr == AW'(ea), "R7 address chain", desc_addr, ea);
        chk(desc_cnt[SB:0] == (SB+1)'(c), "R5 region size", desc_cnt[SB:0], c);
        chk(desc_cnt[SB:0] <= (SB+1)'(SEG), "R4 size cap", desc_cnt[SB:0], SEG);
        chk(desc_cnt[31] == lst && desc_cnt[30:SB+1] == '0, "R6 final flag", desc_cnt, {lst, 31'(c)});
        chk(done == lst, "R8 done timing", done, lst);
        if (lst) chk(done_count == EW'(n), "R8 done count", done_count, n);
        @(posedge clk);
        @(negedge clk);
        desc_ready = 1'b0;
        ea = ea + c;
        er = er - c;
        k++;
      end
      chk(k == n, "R3 entry count", k, n);
      chk(!desc_valid && req_ready, "R7 list ends after length", {desc_valid, req_ready}, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !desc_valid && !done && !err, "R11 reset state",
        {req_ready, desc_valid, done, err}, 8);
    rst_n = 1'b1;
    for (int a = 0; a < 64; a++) begin
      for (int l = 0; l <= 70; l++) begin
        run_req(a, l);
      end
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule